// File: doc/BRIEF.md
# Double-Buffered Isochronous Receive Packet Buffer

This block holds received data for an isochronous OUT endpoint of a USB device controller. It uses two packet buffers in ping-pong fashion. The USB side pushes a byte stream. It ends every packet with an end-of-packet strobe that carries the verdict of an error check made upstream. The processor side pops bytes one at a time through a read strobe and watches a single service flag. The flag means that at least one complete, verified packet is waiting.

Each buffer keeps its own byte count. Buffers fill and drain in strict alternation, so packets leave in the order they arrived. A packet that fails its check gives its buffer back at once. A packet that starts while both buffers still hold unread data is thrown away, and a sticky overrun flag records the loss.

Top module: `iso_rx_pingpong`

## Requirements
- R1: After reset, `rx_service`, `overrun` and `cpu_rd_data` are all 0 and both buffers are empty.
- R2: A packet stores at most MAX_BYTES (256) bytes. A write that arrives while the filling buffer already holds MAX_BYTES bytes is ignored. A packet of exactly MAX_BYTES bytes is complete.
- R3: A short packet ends with `usb_eop`=1 and `usb_pkt_ok`=1; the byte presented in the same cycle, if any, is its last byte. Such a packet raises `rx_service` in the cycle after the end strobe.
- R4: An end strobe with no byte of its own, and no earlier byte in the packet, with `usb_pkt_ok`=1 is a zero-length packet. It raises `rx_service`. A single read then returns 0 and frees its buffer.
- R5: `rx_service` stays 1 until every byte of every held packet has been read. It falls in the cycle after the read of the last held byte.
- R6: A read strobe `cpu_rd_req` returns its byte on `cpu_rd_data` in the following cycle. Bytes come out in arrival order, and the older buffer drains fully before the newer one.
- R7: A packet that ends with `usb_pkt_ok`=0 is discarded: it never raises `rx_service`, and its buffer is reused by the next packet.
- R8: A packet that begins while both buffers hold unread packets is dropped whole. `overrun` becomes 1 and stays 1 until reset, and the held packets read back unchanged.
- R9: A read while `rx_service` is 0 returns 0 and changes no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_wr_valid | input | 1 | A received byte is present |
| usb_wr_data | input | DATA_W | Received byte |
| usb_eop | input | 1 | End of the current packet |
| usb_pkt_ok | input | 1 | Error-check verdict, sampled with usb_eop (1 = good) |
| cpu_rd_req | input | 1 | Processor read strobe, one byte per cycle |
| cpu_rd_data | output | DATA_W | Byte returned one cycle after the strobe |
| rx_service | output | 1 | A complete, verified packet is held |
| overrun | output | 1 | Sticky: a packet was dropped because both buffers were held |

## Verification
The bench builds the block with its default parameters: 8-bit data and a 256-byte maximum packet size. With these values the full-size boundary can be reached directly. This covers a 256-byte packet and a longer stream whose extra bytes must disappear, so the maximum-size and truncation rules are checked at their real limit rather than on a shrunken buffer. Random packet lengths mostly fall well below that limit, with occasional full-size ones. These lengths are mixed with bad verdicts, zero-length packets and partial reads. The mix drives both buffers into the held-and-full condition often enough to exercise overrun and the alternation of buffers.

// File: rtl/iso_rx_pkg.sv
// Package: shared types for the ping-pong receive buffer.
// Assumes exactly two buffers; pointers into them are one bit wide.
package iso_rx_pkg;
    localparam int NBUF = 2;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_BUSY = 2'd1,
        FILL_DROP = 2'd2
    } fill_state_t;
endpackage

// File: rtl/iso_rx_fill_ctrl.sv
// Fill controller: decides which buffer takes an incoming packet, gates byte
// writes at the size limit, and turns the end strobe into a commit or a
// discard. It drops a packet that starts while the target buffer is held.
// Assumes buffers are used in strict alternation, so a held target buffer
// means both buffers are held.
module iso_rx_fill_ctrl
    import iso_rx_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      usb_wr_valid,
    input  logic                      usb_eop,
    input  logic                      usb_pkt_ok,
    input  logic [NBUF-1:0]           bank_ready,
    input  logic [NBUF-1:0][CNT_W-1:0] bank_cnt,
    output logic                      wr_en,
    output logic                      wr_sel,
    output logic                      commit,
    output logic                      discard,
    output logic                      overrun
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    fill_state_t state;
    logic        wr_ptr;
    logic        start;
    logic        active;

    assign wr_sel = wr_ptr;

    // Purpose: decode this cycle's write, commit and discard strobes.
    always_comb begin
        start   = usb_wr_valid | usb_eop;
        active  = (state == FILL_BUSY) ||
                  ((state == FILL_IDLE) && start && !bank_ready[wr_ptr]);
        wr_en   = active && usb_wr_valid && (bank_cnt[wr_ptr] < MAX_CNT);
        commit  = active && usb_eop && usb_pkt_ok;
        discard = active && usb_eop && !usb_pkt_ok;
    end

    // Purpose: packet framing state, fill pointer and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FILL_IDLE;
            wr_ptr  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        if (bank_ready[wr_ptr]) begin
                            overrun <= 1'b1;
                            state   <= usb_eop ? FILL_IDLE : FILL_DROP;
                        end else begin
                            state   <= usb_eop ? FILL_IDLE : FILL_BUSY;
                        end
                    end
                end
                FILL_BUSY: if (usb_eop) state <= FILL_IDLE;
                FILL_DROP: if (usb_eop) state <= FILL_IDLE;
                default:   state <= FILL_IDLE;
            endcase
            if (commit) wr_ptr <= ~wr_ptr;
        end
    end

    // R8: no byte may ever land in a buffer that holds an unread packet.
    assert_no_write_into_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bank_ready[wr_sel]);

    // R8: once set, overrun stays set until reset.
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R7: a dropped packet neither commits nor discards a buffer.
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_DROP) |-> !(commit || discard || wr_en));
endmodule

// File: rtl/iso_rx_bank.sv
// Buffer bank: two packet buffers sharing one storage array. Each buffer has
// a byte counter and a ready bit (complete, verified, unread packet).
// Assumes that the fill side targets only buffers that are not ready and
// that the drain side releases only ready ones.
module iso_rx_bank
    import iso_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 256,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       commit,
    input  logic                       discard,
    input  logic                       release_en,
    input  logic                       rd_sel,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_byte,
    output logic [NBUF-1:0]            ready,
    output logic [NBUF-1:0][CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    logic [DATA_W-1:0] mem [NBUF][MAX_BYTES];

    // Purpose: single write port into the storage of the filling buffer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_sel][cnt[wr_sel][IDX_W-1:0]] <= wr_data;
    end

    assign rd_byte = mem[rd_sel][rd_idx];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic is_wr;
        logic is_rd;
        assign is_wr = (wr_sel == 1'(b));
        assign is_rd = (rd_sel == 1'(b));

        // Purpose: per-buffer byte counter and ready bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[b]   <= '0;
                ready[b] <= 1'b0;
            end else if (is_rd && release_en) begin
                cnt[b]   <= '0;
                ready[b] <= 1'b0;
            end else if (is_wr && discard) begin
                cnt[b]   <= '0;
                ready[b] <= 1'b0;
            end else begin
                if (is_wr && wr_en)  cnt[b]   <= cnt[b] + 1'b1;
                if (is_wr && commit) ready[b] <= 1'b1;
            end
        end

        // R2: a buffer never counts beyond the maximum packet size.
        assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[b] <= MAX_CNT);

        // R7: a discarded buffer is empty and not ready on the next cycle.
        assert_discard_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (is_wr && discard) |=> (!ready[b] && cnt[b] == '0));
    end

    // R3: a commit never targets a buffer that is already held.
    assert_commit_target_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ready[wr_sel]);
endmodule

// File: rtl/iso_rx_drain_ctrl.sv
// Drain controller: serves processor reads from the older held buffer,
// walks its bytes in order, and releases it after the last byte (or after
// one read for a zero-length packet). Reads with nothing held return zero.
// Assumes buffers drain in the same alternation in which they were filled.
module iso_rx_drain_ctrl
    import iso_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 256,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_rd_req,
    input  logic [NBUF-1:0]            bank_ready,
    input  logic [NBUF-1:0][CNT_W-1:0] bank_cnt,
    input  logic [DATA_W-1:0]          rd_byte,
    output logic                       rd_sel,
    output logic [IDX_W-1:0]           rd_idx,
    output logic                       release_en,
    output logic [DATA_W-1:0]          cpu_rd_data
);
    logic             avail;
    logic             empty_pkt;
    logic             last_byte;
    logic [CNT_W-1:0] idx_next;

    // Purpose: decide whether this read ends the current buffer.
    always_comb begin
        avail      = bank_ready[rd_sel];
        idx_next   = {1'b0, rd_idx} + 1'b1;
        empty_pkt  = (bank_cnt[rd_sel] == '0);
        last_byte  = (bank_cnt[rd_sel] == idx_next);
        release_en = cpu_rd_req && avail && (empty_pkt || last_byte);
    end

    // Purpose: read pointer, in-buffer index and the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel      <= 1'b0;
            rd_idx      <= '0;
            cpu_rd_data <= '0;
        end else if (cpu_rd_req) begin
            if (avail) begin
                cpu_rd_data <= empty_pkt ? '0 : rd_byte;
                if (release_en) begin
                    rd_idx <= '0;
                    rd_sel <= ~rd_sel;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end else begin
                cpu_rd_data <= '0;
            end
        end
    end

    // R5: only a held buffer is ever released.
    assert_release_of_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_en |-> bank_ready[rd_sel]);

    // R9: a read with nothing held leaves the read position alone.
    assert_idle_read_no_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_req && (bank_ready == '0)) |=> ($stable(rd_sel) && $stable(rd_idx)));

    // R9: a read with nothing held returns zero.
    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_req && (bank_ready == '0)) |=> (cpu_rd_data == '0));
endmodule

// File: rtl/iso_rx_pingpong.sv
// Top: double-buffered receive packet buffer for an isochronous OUT
// endpoint. Connects the fill controller, the two-buffer bank and the drain
// controller, and raises the service flag while any verified packet is held.
// Assumes the error-check verdict is valid in the cycle of the end strobe.
module iso_rx_pingpong
    import iso_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_wr_valid,
    input  logic [DATA_W-1:0] usb_wr_data,
    input  logic              usb_eop,
    input  logic              usb_pkt_ok,
    input  logic              cpu_rd_req,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic              rx_service,
    output logic              overrun
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int IDX_W = $clog2(MAX_BYTES);

    logic                       wr_en;
    logic                       wr_sel;
    logic                       commit;
    logic                       discard;
    logic                       release_en;
    logic                       rd_sel;
    logic [IDX_W-1:0]           rd_idx;
    logic [DATA_W-1:0]          rd_byte;
    logic [NBUF-1:0]            bank_ready;
    logic [NBUF-1:0][CNT_W-1:0] bank_cnt;

    iso_rx_fill_ctrl #(.MAX_BYTES(MAX_BYTES)) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .usb_wr_valid (usb_wr_valid),
        .usb_eop      (usb_eop),
        .usb_pkt_ok   (usb_pkt_ok),
        .bank_ready   (bank_ready),
        .bank_cnt     (bank_cnt),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .commit       (commit),
        .discard      (discard),
        .overrun      (overrun)
    );

    iso_rx_bank #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (usb_wr_data),
        .commit     (commit),
        .discard    (discard),
        .release_en (release_en),
        .rd_sel     (rd_sel),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte),
        .ready      (bank_ready),
        .cnt        (bank_cnt)
    );

    iso_rx_drain_ctrl #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd_req  (cpu_rd_req),
        .bank_ready  (bank_ready),
        .bank_cnt    (bank_cnt),
        .rd_byte     (rd_byte),
        .rd_sel      (rd_sel),
        .rd_idx      (rd_idx),
        .release_en  (release_en),
        .cpu_rd_data (cpu_rd_data)
    );

    assign rx_service = |bank_ready;

    // R5: the service flag only falls right after a buffer release.
    assert_service_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_service) |-> $past(release_en));

    // R3: the service flag only rises right after a good end strobe.
    assert_service_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_service) |-> $past(commit && usb_eop && usb_pkt_ok));

    // R7: commit and discard never happen together.
    assert_commit_xor_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && discard));
endmodule

// File: tb/iso_rx_pingpong_tb.sv
// Bench: directed corner cases, then seeded random packets and reads,
// compared against a two-slot reference model kept in the bench.
module iso_rx_pingpong_tb;
    localparam int DW  = 8;
    localparam int MAX = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usb_wr_valid = 1'b0;
    logic [DW-1:0] usb_wr_data = '0;
    logic          usb_eop = 1'b0;
    logic          usb_pkt_ok = 1'b0;
    logic          cpu_rd_req = 1'b0;
    logic [DW-1:0] cpu_rd_data;
    logic          rx_service;
    logic          overrun;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model: up to two held packets in a ring.
    logic [DW-1:0] mdat [2][MAX];
    int mlen [2];
    int mhead = 0;
    int mcnt  = 0;
    int midx  = 0;
    bit movr  = 0;

    always #10 clk = ~clk;

    iso_rx_pingpong #(.DATA_W(DW), .MAX_BYTES(MAX)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .usb_wr_valid (usb_wr_valid),
        .usb_wr_data  (usb_wr_data),
        .usb_eop      (usb_eop),
        .usb_pkt_ok   (usb_pkt_ok),
        .cpu_rd_req   (cpu_rd_req),
        .cpu_rd_data  (cpu_rd_data),
        .rx_service   (rx_service),
        .overrun      (overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next byte a read should return, per R4/R6/R9; updates the model.
    function automatic int model_read();
        int v;
        if (mcnt == 0) return 0;
        if (mlen[mhead] == 0) begin
            v = 0;
        end else begin
            v = int'(mdat[mhead][midx]);
            midx++;
        end
        if (midx >= mlen[mhead]) begin
            midx  = 0;
            mhead = (mhead + 1) % 2;
            mcnt--;
        end
        return v;
    endfunction

    // Send one packet of len bytes (len 0 is a lone end strobe).
    task automatic send_pkt(input int len, input bit ok);
        int slot;
        bit held;
        held = (mcnt < 2);
        slot = (mhead + mcnt) % 2;
        if (!held) movr = 1;
        if (len == 0) begin
            @(negedge clk);
            usb_eop = 1'b1; usb_pkt_ok = ok;
        end else begin
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                usb_wr_valid = 1'b1;
                usb_wr_data  = DW'($urandom);
                usb_eop      = (i == len - 1);
                usb_pkt_ok   = ok;
                if (held && i < MAX) mdat[slot][i] = usb_wr_data;
            end
        end
        @(negedge clk);
        usb_wr_valid = 1'b0; usb_eop = 1'b0; usb_pkt_ok = 1'b0;
        if (held && ok) begin
            mlen[slot] = (len > MAX) ? MAX : len;
            mcnt++;
        end
    endtask

    task automatic do_read(input string req);
        int exp;
        exp = model_read();
        @(negedge clk);
        cpu_rd_req = 1'b1;
        @(negedge clk);
        cpu_rd_req = 1'b0;
        chk(req, int'(cpu_rd_data), exp);
        chk({req, " service"}, int'(rx_service), int'(mcnt != 0));
    endtask

    task automatic drain_all(input string req);
        while (mcnt != 0) do_read(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..all actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 service", int'(rx_service), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 data", int'(cpu_rd_data), 0);

        // R9: reads with nothing held return zero and change nothing.
        do_read("R9 idle read");
        do_read("R9 idle read");

        // R3: short good packet raises service after end strobe.
        send_pkt(5, 1'b1);
        chk("R3 service up", int'(rx_service), 1);
        drain_all("R3 short read");
        chk("R5 service down", int'(rx_service), 0);

        // R4: zero-length packet.
        send_pkt(0, 1'b1);
        chk("R4 zero service", int'(rx_service), 1);
        do_read("R4 zero read");
        chk("R4 zero freed", int'(rx_service), 0);

        // R7: bad packet is discarded, its buffer reused.
        send_pkt(7, 1'b0);
        chk("R7 bad no service", int'(rx_service), 0);
        send_pkt(3, 1'b1);
        drain_all("R7 reuse read");

        // R2: exact max size, then oversize stream truncated.
        send_pkt(MAX, 1'b1);
        drain_all("R2 full read");
        send_pkt(MAX + 4, 1'b1);
        drain_all("R2 truncated read");
        chk("R2 after truncation", int'(rx_service), 0);

        // R6/R5: two packets, older first, service held across both.
        send_pkt(3, 1'b1);
        send_pkt(2, 1'b1);
        drain_all("R6 order read");

        // R8: third packet while both held is dropped.
        send_pkt(4, 1'b1);
        send_pkt(6, 1'b1);
        chk("R8 overrun before", int'(overrun), 0);
        send_pkt(5, 1'b1);
        chk("R8 overrun set", int'(overrun), 1);
        drain_all("R8 held intact");
        send_pkt(2, 1'b1);
        drain_all("R8 after drop");
        chk("R8 overrun sticky", int'(overrun), 1);

        // Random mix.
        for (int it = 0; it < 150; it++) begin
            int len;
            int nrd;
            bit ok;
            len = ($urandom % 8 == 0) ? (250 + int'($urandom % 10)) : int'($urandom % 24);
            ok  = ($urandom % 5 != 0);
            send_pkt(len, ok);
            chk("R3 random service", int'(rx_service), int'(mcnt != 0));
            chk("R8 random overrun", int'(overrun), int'(movr));
            nrd = int'($urandom % 30);
            for (int k = 0; k < nrd; k++) do_read("R6 random read");
        end
        drain_all("R5 final drain");
        do_read("R9 final idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule